// File: doc/BRIEF.md
# Minimal 16-bit Instruction Execution Core

This block is a small multi-cycle processor that runs three instructions taken from a 16-bit compressed encoding: add of two registers, move of an 8-bit constant, and add of an 8-bit constant to a register. It holds sixteen 32-bit registers. Register 15 is the program counter and counts in bytes. Instruction memory is addressed in halfwords. Each instruction takes three clock cycles. The first state reads the instruction at the program counter and moves the counter on by 2. The second state splits the instruction into its fields and latches the operands. The third state writes the destination register and the condition flags.

The program store sits inside the block. A write port fills it while reset is held low, and reset leaves its contents alone. Any encoding outside the three supported forms sets a sticky undefined-instruction flag. The core then stops in a halt state until the next reset. A debug select port reads any register, r15 included, so a bench can check the architectural state at the ports.

Top module: `hw16_core`

## Requirements
- R1: While reset is low and on the first cycle after it, every register reads 0, the program counter is 0, the status word is 0, the state is fetch (code 0) and the undefined flag is clear.
- R2: State codes are fetch=0, decode=1, execute=2, halt=3. A supported instruction runs fetch, decode, execute and back to fetch, one cycle each. The program counter goes up by 2 only at the end of fetch.
- R3: The move form has bits 15:11 = 00100, the destination in bits 10:8 and a constant in bits 7:0. It writes the zero-extended constant, sets N and Z from that value, and leaves C and V as they were.
- R4: The register-add form has bits 15:9 = 0001100, Rm in bits 8:6, Rn in bits 5:3 and Rd in bits 2:0. It writes Rn + Rm modulo 2^32 into Rd and updates all four flags.
- R5: The constant-add form has bits 15:11 = 00110, the register in bits 10:8 and a constant in bits 7:0. It writes that register plus the zero-extended constant back into the same register and updates all four flags.
- R6: After an add, C is the carry out of bit 31 when both operands are read as unsigned.
- R7: After an add, V is set exactly when both operands have the same sign and the sign of the result differs from it.
- R8: After any of the three instructions, N equals bit 31 of the result and Z is set exactly when the result is 0. The status word holds N, Z, C and V in bits 31, 30, 29 and 28, and all its other bits read 0.
- R9: An unsupported encoding sets the undefined flag and puts the core in the halt state. From then until reset, no register, flag or program-counter value changes, and later instructions are never executed.
- R10: A program that moves 1 into r0, moves 2 into r1 and then adds r0 and r1 into r2 (words 0x2001, 0x2102, 0x1842) leaves 3 in r2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Program-store write enable |
| prog_addr | input | 6 | Program-store halfword index |
| prog_data | input | 16 | Instruction word to store |
| dbg_sel | input | 4 | Register to observe (15 = program counter) |
| dbg_val | output | 32 | Value of the selected register |
| status_word | output | 32 | Status word, N Z C V in bits 31:28 |
| state_code | output | 2 | Current sequencer state |
| undef_flag | output | 1 | Sticky undefined-instruction flag |

## Verification
If an operand latch or the destination decode goes wrong, a register ends up with the wrong value. The check after halt sees this at dbg_val, and it traces back to the instruction that caused it. A flag computed wrongly, or a C or V cleared by a move, shows on status_word as soon as the execute cycle ends. Later instructions can overwrite it, so each program ends with the instruction whose flags are under test. A sequencing fault shows on state_code and on the program counter within one or two cycles, and it also moves the final program counter away from its expected value.

// File: rtl/hw16_pkg.sv
// Package hw16_pkg: types shared by the core and its submodules.
// Assumes a 32-bit datapath and a 16-bit instruction word.
package hw16_pkg;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_HALT   = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_ADD_REG = 2'd0,
        OP_MOV_IMM = 2'd1,
        OP_ADD_IMM = 2'd2,
        OP_BAD     = 2'd3
    } op_kind_t;

    typedef struct packed {
        op_kind_t   kind;
        logic [2:0] dst;
        logic [2:0] src_a;
        logic [2:0] src_b;
        logic [7:0] imm;
    } dec_fields_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cond_flags_t;

endpackage

// File: rtl/hw16_decode.sv
// hw16_decode: turns a 16-bit instruction word into an operation kind
// and register/constant fields. Purely combinational.
// Assumes only the three supported forms; anything else maps to OP_BAD.
module hw16_decode
    import hw16_pkg::*;
(
    input  logic [15:0] instr,
    output dec_fields_t fields
);
    localparam logic [6:0] ADD_REG_CODE = 7'b0001100;
    localparam logic [4:0] MOV_IMM_CODE = 5'b00100;
    localparam logic [4:0] ADD_IMM_CODE = 5'b00110;

    // Match the opcode fields and pick the operand fields per form.
    always_comb begin
        fields       = '0;
        fields.kind  = OP_BAD;
        fields.imm   = instr[7:0];
        if (instr[15:9] == ADD_REG_CODE) begin
            fields.kind  = OP_ADD_REG;
            fields.dst   = instr[2:0];
            fields.src_a = instr[5:3];
            fields.src_b = instr[8:6];
        end else if (instr[15:11] == MOV_IMM_CODE) begin
            fields.kind  = OP_MOV_IMM;
            fields.dst   = instr[10:8];
        end else if (instr[15:11] == ADD_IMM_CODE) begin
            fields.kind  = OP_ADD_IMM;
            fields.dst   = instr[10:8];
            fields.src_a = instr[10:8];
        end
    end
endmodule

// File: rtl/hw16_alu.sv
// hw16_alu: computes the result and next condition flags for one
// operation. Combinational. For a move, the result is operand b,
// and C and V pass through from the incoming flags.
module hw16_alu
    import hw16_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  op_kind_t          kind,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  cond_flags_t       flags_in,
    output logic [XLEN-1:0]   result,
    output cond_flags_t       flags_out
);
    localparam int unsigned MSB = XLEN - 1;

    logic [XLEN:0] wide_sum;

    // Full-width sum with the carry out kept in the top bit.
    always_comb wide_sum = {1'b0, opa} + {1'b0, opb};

    // Pick the result and derive the flags by operation kind.
    always_comb begin
        flags_out = flags_in;
        if (kind == OP_MOV_IMM) begin
            result = opb;
        end else begin
            result      = wide_sum[MSB:0];
            flags_out.c = wide_sum[XLEN];
            flags_out.v = (opa[MSB] == opb[MSB]) && (wide_sum[MSB] != opa[MSB]);
        end
        flags_out.n = result[MSB];
        flags_out.z = (result == '0);
    end
endmodule

// File: rtl/hw16_regfile.sv
// hw16_regfile: general registers r0..r(NREG-2) with one write port
// and three read ports. The top entry (the program counter) lives
// outside, so reads of that index return 0 here.
// Assumes a synchronous active-low reset that clears every entry.
module hw16_regfile #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 16,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [IW-1:0]   ra,
    input  logic [IW-1:0]   rb,
    input  logic [IW-1:0]   rdbg,
    output logic [XLEN-1:0] qa,
    output logic [XLEN-1:0] qb,
    output logic [XLEN-1:0] qdbg
);
    localparam int unsigned NGEN = NREG - 1;

    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g < NGEN) begin : g_store
            // Hold one general register; load it when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (we && (waddr == IW'(g)))
                    regs[g] <= wdata;
            end
        end else begin : g_none
            // The program-counter slot is not stored here.
            always_comb regs[g] = '0;
        end
    end

    // Asynchronous read ports.
    always_comb begin
        qa   = regs[ra];
        qb   = regs[rb];
        qdbg = regs[rdbg];
    end
endmodule

// File: rtl/hw16_core.sv
// hw16_core: three-state processor running register add, constant move
// and constant add. Holds the sequencer, program counter, instruction
// and operand latches, flags and the program store.
// Assumes the store is filled through prog_* while rst_n is low; reset
// does not clear the store.
module hw16_core
    import hw16_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned NREG       = 16,
    parameter int unsigned IMEM_WORDS = 64,
    localparam int unsigned IW        = $clog2(NREG),
    localparam int unsigned AW        = $clog2(IMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_we,
    input  logic [AW-1:0]   prog_addr,
    input  logic [15:0]     prog_data,
    input  logic [IW-1:0]   dbg_sel,
    output logic [XLEN-1:0] dbg_val,
    output logic [XLEN-1:0] status_word,
    output logic [1:0]      state_code,
    output logic            undef_flag
);
    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

    logic [15:0]     imem [IMEM_WORDS];
    seq_state_t      state;
    logic [XLEN-1:0] pc;
    logic [15:0]     ir;
    dec_fields_t     dec_now;
    dec_fields_t     dec_q;
    logic [XLEN-1:0] opa_q, opb_q;
    cond_flags_t     flags, flags_nx;
    logic [XLEN-1:0] alu_res;
    logic [XLEN-1:0] rf_qa, rf_qb, rf_qdbg;
    logic            undef_q;
    logic            rf_we;

    // Program store write port; contents survive reset.
    always_ff @(posedge clk) begin
        if (prog_we)
            imem[prog_addr] <= prog_data;
    end

    hw16_decode u_dec (
        .instr  (ir),
        .fields (dec_now)
    );

    hw16_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr ({1'b0, dec_q.dst}),
        .wdata (alu_res),
        .ra    ({1'b0, dec_now.src_a}),
        .rb    ({1'b0, dec_now.src_b}),
        .rdbg  (dbg_sel),
        .qa    (rf_qa),
        .qb    (rf_qb),
        .qdbg  (rf_qdbg)
    );

    hw16_alu #(.XLEN(XLEN)) u_alu (
        .kind      (dec_q.kind),
        .opa       (opa_q),
        .opb       (opb_q),
        .flags_in  (flags),
        .result    (alu_res),
        .flags_out (flags_nx)
    );

    // Register writes happen only in the execute state.
    always_comb rf_we = (state == ST_EXEC);

    // Sequencer: fetch, decode, execute, or park in halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FETCH;
            pc      <= '0;
            ir      <= '0;
            dec_q   <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            flags   <= '0;
            undef_q <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir    <= imem[pc[AW:1]];
                    pc    <= pc + XLEN'(2);
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    dec_q <= dec_now;
                    opa_q <= rf_qa;
                    opb_q <= (dec_now.kind == OP_ADD_REG) ? rf_qb
                                                          : XLEN'(dec_now.imm);
                    if (dec_now.kind == OP_BAD) begin
                        undef_q <= 1'b1;
                        state   <= ST_HALT;
                    end else begin
                        state   <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    flags <= flags_nx;
                    state <= ST_FETCH;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // Output views: debug read with the PC in the top slot, status word.
    always_comb begin
        dbg_val     = (dbg_sel == PC_IDX) ? pc : rf_qdbg;
        status_word = '0;
        status_word[XLEN-1:XLEN-4] = {flags.n, flags.z, flags.c, flags.v};
        state_code  = state;
        undef_flag  = undef_q;
    end
endmodule

// File: rtl/hw16_core_chk.sv
// hw16_core_chk: temporal checks on the core's sequencer, program
// counter and flags, attached to every hw16_core instance by bind.
module hw16_core_chk
    import hw16_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input seq_state_t      state,
    input logic [XLEN-1:0] pc,
    input cond_flags_t     flags,
    input dec_fields_t     dec_q,
    input logic            undef_q
);
    a_r1_reset_pc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0 && state == ST_FETCH && !undef_q));

    a_r2_fetch_next: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> state == ST_DECODE);

    a_r2_decode_next: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DECODE |=> (state == ST_EXEC || state == ST_HALT));

    a_r2_exec_next: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EXEC |=> state == ST_FETCH);

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> pc == $past(pc) + XLEN'(2));

    a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_FETCH |=> $stable(pc));

    a_r3_mov_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && dec_q.kind == OP_MOV_IMM) |=> ($stable(flags.c) && $stable(flags.v)));

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HALT |=> (state == ST_HALT && $stable(pc) && $stable(flags)));

    a_r9_undef_halts: assert property (@(posedge clk) disable iff (!rst_n)
        undef_q |-> state == ST_HALT);
endmodule

bind hw16_core hw16_core_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .pc      (pc),
    .flags   (flags),
    .dec_q   (dec_q),
    .undef_q (undef_q)
);

// File: tb/sim_hw16_core.sv
`timescale 1ns/100ps
module sim_hw16_core;
    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic [3:0]  dbg_sel = '0;
    logic [31:0] dbg_val, status_word;
    logic [1:0]  state_code;
    logic        undef_flag;

    int n_checks = 0;
    int n_fail = 0;

    // kind: 0 register via dbg_sel, 1 status word, 2 state code and PC, 3 undefined flag
    typedef struct {
        int          kind;
        logic [3:0]  sel;
        logic [31:0] exp;
        logic [31:0] exp2;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    logic [15:0] prog [WORDS];

    always #2.5 clk = ~clk;

    hw16_core u0 (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .dbg_sel(dbg_sel), .dbg_val(dbg_val),
        .status_word(status_word), .state_code(state_code), .undef_flag(undef_flag)
    );

    function automatic void compare(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endfunction

    // Driver side: queue an expected item.
    task automatic push(int kind, logic [3:0] sel, logic [31:0] exp, logic [31:0] exp2, string tag);
        sb_item_t it;
        it.kind = kind; it.sel = sel; it.exp = exp; it.exp2 = exp2; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: one item per cycle, sampled mid-cycle after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1.5;
            if (sb_q.size() != 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                dbg_sel = it.sel;
                #0.5;
                case (it.kind)
                    0: compare(it.tag, dbg_val, it.exp);
                    1: compare(it.tag, status_word, it.exp);
                    2: begin
                        compare(it.tag, {30'd0, state_code}, it.exp);
                        compare(it.tag, dbg_val, it.exp2);
                    end
                    default: compare(it.tag, {31'd0, undef_flag}, it.exp);
                endcase
            end
        end
    end

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Hold reset and write the whole program store.
    task automatic load_and_reset();
        rst_n = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_to_halt(string tag);
        int cyc = 0;
        rst_n = 1'b1;
        while (state_code != 2'd3 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (state_code != 2'd3) begin
            n_checks++; n_fail++;
            $display("FAIL %s: actual no halt after %0d cycles expected halt", tag, cyc);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < WORDS; i++) prog[i] = 16'h0000;
    endtask

    initial begin
        // Program A: 1+2, constant add, doubling to 2^31, wrap to zero, move keeps C/V.
        clear_prog();
        prog[0] = 16'h2001;                       // mov r0,#1
        prog[1] = 16'h2102;                       // mov r1,#2
        prog[2] = 16'h1842;                       // add r2,r0,r1
        prog[3] = 16'h23FF;                       // mov r3,#255
        prog[4] = 16'h3301;                       // add r3,#1
        prog[5] = 16'h2401;                       // mov r4,#1
        for (int i = 6; i < 37; i++) prog[i] = 16'h1924; // add r4,r4,r4
        prog[37] = 16'h1925;                      // add r5,r4,r4 -> 0, C, V, Z
        prog[38] = 16'h2680;                      // mov r6,#0x80
        prog[39] = 16'h0000;                      // unsupported -> halt
        load_and_reset();

        // R1: reset state, read during reset.
        for (int r = 0; r < 15; r++) push(0, 4'(r), 32'h0, 32'h0, "R1 reg after reset");
        push(2, 4'hF, 32'd0, 32'd0, "R1 state/pc in reset");
        push(1, 4'h0, 32'h0, 32'h0, "R1 status in reset");
        push(3, 4'h0, 32'h0, 32'h0, "R1 undef in reset");
        drain();

        // R2: the sequence over the first instruction, sampled each cycle after release.
        rst_n = 1'b1;
        push(2, 4'hF, 32'd1, 32'd2, "R2 decode after fetch");
        push(2, 4'hF, 32'd2, 32'd2, "R2 execute");
        push(2, 4'hF, 32'd0, 32'd2, "R2 back to fetch");
        push(2, 4'hF, 32'd1, 32'd4, "R2 next decode");
        drain();
        run_to_halt("R9 program A");

        push(0, 4'd2, 32'd3, 32'h0, "R10 r2 = 1+2");
        push(0, 4'd0, 32'd1, 32'h0, "R3 mov r0");
        push(0, 4'd1, 32'd2, 32'h0, "R3 mov r1");
        push(0, 4'd3, 32'h100, 32'h0, "R5 add constant r3");
        push(0, 4'd4, 32'h8000_0000, 32'h0, "R4 doubling r4");
        push(0, 4'd5, 32'h0, 32'h0, "R6 wrap to zero r5");
        push(0, 4'd6, 32'h80, 32'h0, "R3 mov r6");
        push(1, 4'h0, 32'h3000_0000, 32'h0, "R3 mov keeps C,V, clears N,Z");
        push(2, 4'hF, 32'd3, 32'd80, "R9 halted pc");
        push(3, 4'h0, 32'h1, 32'h0, "R9 undef flag");
        drain();

        // Program B: end on the last doubling: N and V set, C and Z clear.
        clear_prog();
        prog[0] = 16'h2401;
        for (int i = 1; i < 32; i++) prog[i] = 16'h1924;
        load_and_reset();
        run_to_halt("R9 program B");
        push(1, 4'h0, 32'h9000_0000, 32'h0, "R7 R8 signed overflow flags");
        push(0, 4'd4, 32'h8000_0000, 32'h0, "R4 r4 = 2^31");
        drain();

        // Program C: wrap to zero then stop: Z, C, V set.
        clear_prog();
        prog[0] = 16'h2401;
        for (int i = 1; i < 32; i++) prog[i] = 16'h1924;
        prog[32] = 16'h1925;
        load_and_reset();
        run_to_halt("R9 program C");
        push(1, 4'h0, 32'h7000_0000, 32'h0, "R6 R7 R8 carry zero overflow");
        drain();

        // Program D: constant add without carry, move of zero, then an unsupported word
        // followed by a move that must never run.
        clear_prog();
        prog[0] = 16'h21FF;                       // mov r1,#255
        prog[1] = 16'h31FF;                       // add r1,#255 -> 0x1FE
        prog[2] = 16'h2200;                       // mov r2,#0 -> Z
        prog[3] = 16'hFFFF;                       // unsupported
        prog[4] = 16'h2377;                       // mov r3,#0x77 must not run
        load_and_reset();
        run_to_halt("R9 program D");
        push(0, 4'd1, 32'h1FE, 32'h0, "R5 constant add r1");
        push(1, 4'h0, 32'h4000_0000, 32'h0, "R8 move of zero sets Z");
        push(0, 4'd3, 32'h0, 32'h0, "R9 r3 untouched after halt");
        push(2, 4'hF, 32'd3, 32'd8, "R9 pc frozen");
        push(3, 4'h0, 32'h1, 32'h0, "R9 undef set");
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule